// File: doc/BRIEF.md
# MDIO Clause 45 Reply-Word Slave

This block is the management-bus front end of a device that takes commands over a two-wire MDC/MDIO link. It oversamples MDC and MDIO with the system clock and finds the rising and falling edges of MDC. It then decodes the Clause 45 frame: a run of ones, a start code, an opcode, a port address, a device address, a turnaround and a 16-bit data field. The block acts only on frames sent to its own port and device address.

Address and Write frames are not stored here. Their opcode and 16-bit payload go to a downstream command engine as a single-cycle strobe in the system clock domain. A Read frame does not look anything up in a register file. It returns one "prepared reply" word, which the command engine keeps current after every frame it sees. The slave drives the bus as a push-pull output with a separate enable, and drives both levels for the whole read data phase.

The block deliberately ignores the post-read-increment opcode and any frame whose start code does not match, so a host cannot make it respond outside the three supported frame types.

Top module: `mdio_reply_slave`

## Requirements
- R1: After reset, `mdio_oe_o` is 0 and `frm_valid_o` is 0 until a frame has been decoded.
- R2: A frame starts only after at least PRE_MIN (default 32) consecutive ones are sampled on rising MDC edges, followed by a zero. A zero seen earlier restarts the count, so a frame with 31 leading ones is ignored. A frame with 32 or more leading ones is accepted.
- R3: A frame is acted on only when its 5-bit port address equals PORT_ADDR (default 5) and its 5-bit device address equals DEV_ADDR (default 1). Both addresses are sent MSB first. Any other address gives no strobe and no drive.
- R4: An accepted Address frame (opcode 00) or Write frame (opcode 01) gives exactly one single-cycle `frm_valid_o` pulse. With the pulse, `frm_type_o` equals the opcode and `frm_data_o` equals the 16 data bits, which are sent MSB first.
- R5: Opcode 10 is ignored even when both addresses match: no strobe is produced and the driver stays off.
- R6: In an accepted Read frame (opcode 11), `mdio_oe_o` is 0 during the first turnaround bit. It is 1 during the second turnaround bit, which is driven as 0. It stays 1 through the 16 data bits and is back to 0 in the bit period that follows data bit 0. The output changes only after a falling MDC edge.
- R7: A Read frame returns, MSB first, the value `reply_i` held when the last device-address bit was sampled.
- R8: An accepted Read frame also gives one `frm_valid_o` pulse, with `frm_type_o` = 11 and `frm_data_o` equal to the word sent.
- R9: The start code is 00. A frame whose second start bit is 1 is ignored.
- R10: The block works correctly when each MDC high phase and each MDC low phase lasts at least 4 system clock cycles. A 125 MHz clock therefore serves MDC up to 4 MHz with wide margin. SYNC_STAGES must be at least 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mdc_i | input | 1 | Management clock from the host |
| mdio_i | input | 1 | Management data as seen on the pin |
| mdio_o | output | 1 | Push-pull output data |
| mdio_oe_o | output | 1 | Output enable for the pin driver |
| reply_i | input | 16 | Reply word prepared by the command engine |
| frm_valid_o | output | 1 | One-cycle strobe per accepted frame |
| frm_type_o | output | 2 | Opcode of the accepted frame |
| frm_data_o | output | 16 | Payload of the accepted frame, or the reply word sent |

## Verification
The hardest case to reach from the ports is the handover of the bus during a read. The slave must stay off for the first turnaround bit, then drive a zero, and it must let go exactly one bit after data bit 0. Any error of one MDC edge shows up only as a wrong line level at a single host sample point. The bench models the host as a released line that is overridden by the slave's enable. It records the line level and the enable at every rising MDC edge of the turnaround, the data phase and the following idle bit. The read is repeated with the shortest allowed MDC phases, so that the synchroniser latency is tested against the sampling point.

// File: rtl/mdio_reply_pkg.sv
package mdio_reply_pkg;
   typedef enum logic [1:0] {
      OP_ADDR  = 2'b00,
      OP_WRITE = 2'b01,
      OP_RDINC = 2'b10,
      OP_READ  = 2'b11
   } mdio_op_e;

   localparam int unsigned ADR_W = 5;
   localparam int unsigned OP_W  = 2;
   localparam int unsigned ST_W  = 2;
   localparam int unsigned TA_W  = 2;
endpackage

// File: rtl/mdio_sync.sv
module mdio_sync #(
   parameter int unsigned WIDTH   = 2,
   parameter int unsigned STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   initial begin
      AST_SYNC_DEPTH: assert (STAGES >= 2) else $error("sync depth too small"); // R10
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
         else        chain <= {chain[STAGES-2:0], d_i[b]};
      end
      assign q_o[b] = chain[STAGES-1];
   end
endmodule

// File: rtl/mdio_frame_rx.sv
module mdio_frame_rx
   import mdio_reply_pkg::*;
#(
   parameter int unsigned       DATA_W    = 16,
   parameter int unsigned       PRE_MIN   = 32,
   parameter logic [ADR_W-1:0]  PORT_ADDR = 5'd5,
   parameter logic [ADR_W-1:0]  DEV_ADDR  = 5'd1,
   parameter logic [ST_W-1:0]   ST_CODE   = 2'b00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rise_s,
   input  logic              mdio_s,
   input  logic [DATA_W-1:0] reply_i,
   output logic              tx_start,
   output logic [DATA_W-1:0] tx_word,
   output logic              hit_rd,
   output logic              frm_valid,
   output mdio_op_e          frm_type,
   output logic [DATA_W-1:0] frm_data
);
   localparam int unsigned HDR_BITS   = ST_W + OP_W + 2 * ADR_W;
   localparam int unsigned FRAME_BITS = HDR_BITS + TA_W + DATA_W;
   localparam int unsigned LAST_IDX   = FRAME_BITS - 1;
   localparam int unsigned IDX_W      = $clog2(FRAME_BITS);
   localparam int unsigned PRE_W      = $clog2(PRE_MIN + 1);

   initial begin
      AST_ST_LEAD_ZERO: assert (ST_CODE[1] == 1'b0) else $error("start code must open with 0"); // R9
      AST_PRE_NONZERO:  assert (PRE_MIN >= 1) else $error("preamble length must be positive");  // R2
      AST_DATA_WIDTH:   assert (DATA_W >= 2) else $error("data width too small");              // R4
   end

   logic                in_frame;
   logic [IDX_W-1:0]    idx;
   logic [PRE_W-1:0]    pre_cnt;
   logic [HDR_BITS-1:0] hdr_sh;
   logic [HDR_BITS-1:0] hdr_next;
   logic [DATA_W-1:0]   dat_sh;
   logic [DATA_W-1:0]   dat_next;
   logic                hit;
   mdio_op_e            op_q;
   logic [DATA_W-1:0]   rd_word;

   logic [ST_W-1:0]  st_f;
   mdio_op_e         op_f;
   logic [ADR_W-1:0] pa_f;
   logic [ADR_W-1:0] da_f;
   logic             hdr_ok;

   always_comb begin
      hdr_next = {hdr_sh[HDR_BITS-2:0], mdio_s};
      dat_next = {dat_sh[DATA_W-2:0], mdio_s};
      st_f     = hdr_next[HDR_BITS-1 -: ST_W];
      op_f     = mdio_op_e'(hdr_next[HDR_BITS-ST_W-1 -: OP_W]);
      pa_f     = hdr_next[2*ADR_W-1 -: ADR_W];
      da_f     = hdr_next[ADR_W-1:0];
      hdr_ok   = (st_f == ST_CODE) && (pa_f == PORT_ADDR) &&
                 (da_f == DEV_ADDR) && (op_f != OP_RDINC);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_frame  <= 1'b0;
         idx       <= '0;
         pre_cnt   <= '0;
         hdr_sh    <= '0;
         dat_sh    <= '0;
         hit       <= 1'b0;
         hit_rd    <= 1'b0;
         op_q      <= OP_ADDR;
         rd_word   <= '0;
         tx_start  <= 1'b0;
         frm_valid <= 1'b0;
         frm_type  <= OP_ADDR;
         frm_data  <= '0;
      end else begin
         frm_valid <= 1'b0;
         tx_start  <= 1'b0;
         if (rise_s) begin
            if (!in_frame) begin
               if (mdio_s) begin
                  if (pre_cnt != PRE_W'(PRE_MIN)) pre_cnt <= pre_cnt + 1'b1;
               end else begin
                  if (pre_cnt == PRE_W'(PRE_MIN)) begin
                     in_frame <= 1'b1;
                     idx      <= IDX_W'(1);
                     hdr_sh   <= '0;
                  end
                  pre_cnt <= '0;
               end
            end else begin
               hdr_sh <= hdr_next;
               dat_sh <= dat_next;
               idx    <= idx + 1'b1;
               if (idx == IDX_W'(HDR_BITS - 1)) begin
                  hit     <= hdr_ok;
                  hit_rd  <= hdr_ok && (op_f == OP_READ);
                  op_q    <= op_f;
                  rd_word <= reply_i;
               end
               if (idx == IDX_W'(HDR_BITS) && hit_rd) tx_start <= 1'b1;
               if (idx == IDX_W'(LAST_IDX)) begin
                  in_frame  <= 1'b0;
                  idx       <= '0;
                  frm_valid <= hit;
                  frm_type  <= op_q;
                  frm_data  <= hit_rd ? rd_word : dat_next;
               end
            end
         end
      end
   end

   assign tx_word = rd_word;

   AST_PRE_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
      pre_cnt <= PRE_W'(PRE_MIN)); // R2
   AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid |=> !frm_valid); // R4
   AST_NO_RDINC_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid |-> (frm_type != OP_RDINC)); // R5
endmodule

// File: rtl/mdio_tx.sv
module mdio_tx #(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fall_s,
   input  logic              start,
   input  logic [DATA_W-1:0] word,
   output logic              mdio_o,
   output logic              mdio_oe
);
   localparam int unsigned SH_W  = DATA_W + 1;
   localparam int unsigned CNT_W = $clog2(SH_W + 1);

   logic             busy;
   logic [CNT_W-1:0] cnt;
   logic [SH_W-1:0]  sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         cnt     <= '0;
         sh      <= '0;
         mdio_o  <= 1'b0;
         mdio_oe <= 1'b0;
      end else if (start) begin
         busy <= 1'b1;
         cnt  <= '0;
         sh   <= {1'b0, word};
      end else if (fall_s && busy) begin
         if (cnt != CNT_W'(SH_W)) begin
            mdio_oe <= 1'b1;
            mdio_o  <= sh[SH_W-1];
            sh      <= {sh[SH_W-2:0], 1'b0};
            cnt     <= cnt + 1'b1;
         end else begin
            mdio_oe <= 1'b0;
            mdio_o  <= 1'b0;
            busy    <= 1'b0;
         end
      end
   end

   AST_TX_ON_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (!fall_s && !start) |=> ($stable(mdio_o) && $stable(mdio_oe))); // R6
endmodule

// File: rtl/mdio_reply_slave.sv
module mdio_reply_slave
   import mdio_reply_pkg::*;
#(
   parameter int unsigned       DATA_W      = 16,
   parameter int unsigned       PRE_MIN     = 32,
   parameter int unsigned       SYNC_STAGES = 2,
   parameter logic [ADR_W-1:0]  PORT_ADDR   = 5'd5,
   parameter logic [ADR_W-1:0]  DEV_ADDR    = 5'd1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              mdc_i,
   input  logic              mdio_i,
   output logic              mdio_o,
   output logic              mdio_oe_o,
   input  logic [DATA_W-1:0] reply_i,
   output logic              frm_valid_o,
   output logic [1:0]        frm_type_o,
   output logic [DATA_W-1:0] frm_data_o
);
   logic [1:0]        pins_s;
   logic              mdc_s;
   logic              mdio_s;
   logic              mdc_prev;
   logic              rise_s;
   logic              fall_s;
   logic              tx_start;
   logic [DATA_W-1:0] tx_word;
   logic              hit_rd;
   mdio_op_e          frm_type;

   mdio_sync #(
      .WIDTH   (2),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (2'b00)
   ) sync_i (
      .clk   (clk_i),
      .rst_n (rst_ni),
      .d_i   ({mdc_i, mdio_i}),
      .q_o   (pins_s)
   );

   assign mdc_s  = pins_s[1];
   assign mdio_s = pins_s[0];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mdc_prev <= 1'b0;
      else         mdc_prev <= mdc_s;
   end

   assign rise_s = mdc_s & ~mdc_prev;
   assign fall_s = ~mdc_s & mdc_prev;

   mdio_frame_rx #(
      .DATA_W    (DATA_W),
      .PRE_MIN   (PRE_MIN),
      .PORT_ADDR (PORT_ADDR),
      .DEV_ADDR  (DEV_ADDR),
      .ST_CODE   (2'b00)
   ) rx_i (
      .clk       (clk_i),
      .rst_n     (rst_ni),
      .rise_s    (rise_s),
      .mdio_s    (mdio_s),
      .reply_i   (reply_i),
      .tx_start  (tx_start),
      .tx_word   (tx_word),
      .hit_rd    (hit_rd),
      .frm_valid (frm_valid_o),
      .frm_type  (frm_type),
      .frm_data  (frm_data_o)
   );

   assign frm_type_o = frm_type;

   mdio_tx #(
      .DATA_W (DATA_W)
   ) tx_i (
      .clk     (clk_i),
      .rst_n   (rst_ni),
      .fall_s  (fall_s),
      .start   (tx_start),
      .word    (tx_word),
      .mdio_o  (mdio_o),
      .mdio_oe (mdio_oe_o)
   );

   AST_OE_ONLY_FOR_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(mdio_oe_o) |-> hit_rd); // R6
   AST_RD_STROBE_TYPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frm_valid_o && hit_rd) |-> (frm_type_o == 2'b11)); // R8
endmodule

// File: tb/mdio_reply_slave_tb_top.sv
module mdio_reply_slave_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mdc = 1'b1;
   logic        host_bit = 1'b1;
   logic        mdio_line;
   logic        dut_o;
   logic        dut_oe;
   logic [15:0] reply = 16'h0000;
   logic        frm_valid;
   logic [1:0]  frm_type;
   logic [15:0] frm_data;

   int          checks = 0;
   int          errors = 0;
   int          half = 6;
   bit          done = 1'b0;

   int          stb_cnt = 0;
   int          oe_cnt = 0;
   logic [1:0]  last_type = 2'b00;
   logic [15:0] last_data = 16'h0000;

   always #4 clk = ~clk;

   assign mdio_line = dut_oe ? dut_o : host_bit;

   mdio_reply_slave dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .mdc_i       (mdc),
      .mdio_i      (mdio_line),
      .mdio_o      (dut_o),
      .mdio_oe_o   (dut_oe),
      .reply_i     (reply),
      .frm_valid_o (frm_valid),
      .frm_type_o  (frm_type),
      .frm_data_o  (frm_data)
   );

   always @(posedge clk) begin
      if (frm_valid) begin
         stb_cnt   <= stb_cnt + 1;
         last_type <= frm_type;
         last_data <= frm_data;
      end
      if (dut_oe) oe_cnt <= oe_cnt + 1;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic io_bit(input logic b, output logic s, output logic oe_s);
      @(negedge clk);
      mdc = 1'b0;
      host_bit = b;
      repeat (half) @(negedge clk);
      s = mdio_line;
      oe_s = dut_oe;
      mdc = 1'b1;
      repeat (half - 1) @(negedge clk);
   endtask

   task automatic run_frame(input int pre_n, input logic [1:0] st, input logic [1:0] op,
                            input logic [4:0] pa, input logic [4:0] da, input logic [15:0] wd,
                            output logic [15:0] rd, output logic ta0_oe, output logic ta1_oe,
                            output logic ta1_v);
      logic s;
      logic o;
      rd = 16'h0000;
      ta0_oe = 1'b0;
      ta1_oe = 1'b0;
      ta1_v = 1'b1;
      for (int i = 0; i < pre_n; i++) io_bit(1'b1, s, o);
      for (int i = 1; i >= 0; i--) io_bit(st[i], s, o);
      for (int i = 1; i >= 0; i--) io_bit(op[i], s, o);
      for (int i = 4; i >= 0; i--) io_bit(pa[i], s, o);
      for (int i = 4; i >= 0; i--) io_bit(da[i], s, o);
      if (op[1]) begin
         io_bit(1'b1, s, o); ta0_oe = o;
         io_bit(1'b1, s, o); ta1_oe = o; ta1_v = s;
         for (int i = 15; i >= 0; i--) begin
            io_bit(1'b1, s, o);
            rd[i] = s;
         end
      end else begin
         io_bit(1'b1, s, o);
         io_bit(1'b0, s, o);
         for (int i = 15; i >= 0; i--) io_bit(wd[i], s, o);
      end
      host_bit = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic frame_expect(input string req, input int pre_n, input logic [1:0] st,
                               input logic [1:0] op, input logic [4:0] pa, input logic [4:0] da,
                               input logic [15:0] wd, input bit exp_stb);
      int s0;
      int o0;
      logic [15:0] rd;
      logic a;
      logic b;
      logic c;
      s0 = stb_cnt;
      o0 = oe_cnt;
      run_frame(pre_n, st, op, pa, da, wd, rd, a, b, c);
      check((stb_cnt - s0) == (exp_stb ? 1 : 0), req, stb_cnt - s0, exp_stb ? 1 : 0);
      if (exp_stb) begin
         check(last_type == op, req, last_type, op);
         check(last_data == wd, req, last_data, wd);
      end
      if (!op[1] || !exp_stb)
         check(oe_cnt == o0, req, oe_cnt - o0, 0);
   endtask

   task automatic read_expect(input string req, input logic [15:0] word);
      int s0;
      logic [15:0] rd;
      logic t0;
      logic t1;
      logic tv;
      logic s;
      logic o;
      reply = word;
      s0 = stb_cnt;
      run_frame(32, 2'b00, 2'b11, 5'd5, 5'd1, 16'h0000, rd, t0, t1, tv);
      check(t0 == 1'b0, {req, " R6 ta0 released"}, t0, 0);
      check(t1 == 1'b1 && tv == 1'b0, {req, " R6 ta1 driven low"}, {t1, tv}, 2'b10);
      check(rd == word, {req, " R7 reply word"}, rd, word);
      check((stb_cnt - s0) == 1 && last_type == 2'b11 && last_data == word,
            {req, " R8 read strobe"}, last_data, word);
      io_bit(1'b1, s, o);
      check(o == 1'b0, {req, " R6 released after bit 0"}, o, 0);
   endtask

   initial begin
      logic [15:0] rd;
      logic a;
      logic b;
      logic c;
      repeat (10) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      // R1: reset state
      check(dut_oe == 1'b0, "R1 oe after reset", dut_oe, 0);
      check(stb_cnt == 0, "R1 no strobe after reset", stb_cnt, 0);

      // R4: write and address frames with distinct payloads
      frame_expect("R4 write", 32, 2'b00, 2'b01, 5'd5, 5'd1, 16'hBEEF, 1'b1);
      frame_expect("R4 address", 32, 2'b00, 2'b00, 5'd5, 5'd1, 16'h3005, 1'b1);
      for (int k = 0; k < 16; k++)
         frame_expect("R4 walking one", 32, 2'b00, {1'b0, k[0]}, 5'd5, 5'd1,
                      16'h0001 << k, 1'b1);

      // R3: sweep of port and device addresses
      for (int p = 0; p < 32; p++)
         frame_expect("R3 port sweep", 32, 2'b00, 2'b01, 5'(p), 5'd1,
                      16'(p * 16'h0111), p == 5);
      for (int d = 0; d < 32; d++)
         frame_expect("R3 device sweep", 32, 2'b00, 2'b00, 5'd5, 5'(d),
                      16'(16'hF000 - d), d == 1);

      // R5: opcode 10 ignored
      frame_expect("R5 rdinc ignored", 32, 2'b00, 2'b10, 5'd5, 5'd1, 16'h0000, 1'b0);
      // R3: mismatched read never drives
      frame_expect("R3 foreign read", 32, 2'b00, 2'b11, 5'd4, 5'd1, 16'h0000, 1'b0);

      // R2: preamble length
      frame_expect("R2 short preamble", 31, 2'b00, 2'b01, 5'd5, 5'd1, 16'h1111, 1'b0);
      frame_expect("R2 exact preamble", 32, 2'b00, 2'b01, 5'd5, 5'd1, 16'h2222, 1'b1);
      frame_expect("R2 long preamble", 40, 2'b00, 2'b01, 5'd5, 5'd1, 16'h4444, 1'b1);
      run_frame(20, 2'b00, 2'b00, 5'd0, 5'd0, 16'h0000, rd, a, b, c);
      frame_expect("R2 broken preamble", 20, 2'b00, 2'b01, 5'd5, 5'd1, 16'h5555, 1'b0);

      // R9: wrong start code
      frame_expect("R9 bad start", 32, 2'b01, 2'b01, 5'd5, 5'd1, 16'h6666, 1'b0);
      frame_expect("R9 recover", 32, 2'b00, 2'b01, 5'd5, 5'd1, 16'h7777, 1'b1);

      // R6 R7 R8: reads with varied reply words
      read_expect("read zero", 16'h0000);
      read_expect("read ones", 16'hFFFF);
      read_expect("read edges", 16'h8001);
      read_expect("read mix", 16'h5AA5);

      // R10: shortest allowed MDC phases
      half = 4;
      read_expect("R10 fast read", 16'hC3A6);
      frame_expect("R10 fast write", 32, 2'b00, 2'b01, 5'd5, 5'd1, 16'h9A1E, 1'b1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule